// File: doc/BRIEF.md
# STS-1 Line and Framing Alarm Detector

This block watches the receive side of an STS-1 line and raises five line-level defect indications as steady alarm levels: receive clock lost, line AIS, out of frame, loss of frame and loss of signal. The raw receive line clock and data are sampled on the system clock through a synchroniser. A separate framing correlator supplies a one-cycle pattern-found pulse tagged with a free-running bit stamp. The overhead extractor supplies the K2 byte of each frame together with a frame strobe.

Two of the alarms are timed windows, measured in system clock cycles derived from the clock frequency parameter. Two are persistence filters over consecutive frames. The out-of-frame alarm is released only by two framing patterns that sit exactly one frame length apart in bit stamps. While loss of frame is active, the K2 strobe can no longer be trusted as a frame marker. The block then makes its own frame tick by counting one frame length of receive bit clocks, so the frame-count filters keep advancing.

Top module: `sts1_line_alarms`

## Requirements
- R1: After reset all five alarm outputs are low.
- R2: `alm_loc` goes high once the synchronised receive clock has shown no transition for LOC_NS nanoseconds (25 system cycles at the defaults). It returns low no more than two cycles after the first synchronised transition.
- R3: `alm_ais` goes high on the fifth consecutive K2 strobe whose K2 bits [2:0] equal 3'b111. Any strobe with another value restarts the count.
- R4: With `alm_ais` high, it goes low on the fifth consecutive K2 strobe whose bits [2:0] differ from 3'b111. A 3'b111 strobe restarts that count.
- R5: `alm_oof` goes high on the fourth consecutive frame tick that had no pattern-found pulse during its frame.
- R6: With `alm_oof` high, it goes low only on a pattern-found pulse whose `fp_pos` minus the previous pulse's `fp_pos` (modulo 2^BPOS_W) equals FRAME_BITS. Pulses at any other spacing leave it high.
- R7: `alm_lof` goes high after eight consecutive frame ticks with `alm_oof` high. It goes low after eight consecutive frame ticks with `alm_oof` low.
- R8: While `alm_lof` is high, frame ticks come from the block itself, one every FRAME_BITS rising edges of the receive clock. They need no K2 strobes, so loss of frame can clear without any.
- R9: `alm_los` is high in the cycle after `ext_sig_ok` is sampled low. It also goes high after LOS_US microseconds of all-zero synchronised data (2500 cycles at the defaults).
- R10: `alm_los` stays high until a pattern-found pulse arrives while `ext_sig_ok` is high and no zero run is active. It then goes low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line_clk | input | 1 | Receive line clock, asynchronous, sampled |
| rx_line_dat | input | 1 | Scrambled receive line data, asynchronous, sampled |
| ext_sig_ok | input | 1 | External signal-present input, low means signal lost |
| fp_found | input | 1 | One-cycle pulse: framing pattern detected |
| fp_pos | input | BPOS_W | Free-running bit stamp of the detected pattern |
| k2_byte | input | 8 | K2 overhead byte of the current frame |
| k2_stb | input | 1 | One-cycle strobe marking a valid `k2_byte` and a frame boundary |
| alm_loc | output | 1 | Receive clock lost |
| alm_ais | output | 1 | Line AIS |
| alm_lof | output | 1 | Loss of frame |
| alm_oof | output | 1 | Out of frame |
| alm_los | output | 1 | Loss of signal |

## Verification
The embedded properties check cycle-level rules on every clock. A set alarm changes only on a frame tick. The out-of-frame alarm rises only on a tick and falls only on a pattern pulse. Loss of signal follows a low external input in the next cycle and falls only on a qualified pattern pulse. The clock-loss alarm drops two cycles after a receive clock transition. The bench scenarios alone can show the counting behaviour: exact five- and eight-frame thresholds, restarts on a broken run, rejection of a pattern pair at the wrong spacing, the timed windows for clock loss and zero data, and loss of frame clearing on internally generated frame ticks.

// File: rtl/sts1_alarm_pkg.sv
package sts1_alarm_pkg;

  // Cycles needed to cover a window given in nanoseconds, rounded up.
  function automatic int cyc_from_ns(input int clk_mhz, input int ns);
    return (clk_mhz * ns + 999) / 1000;
  endfunction

  // Cycles needed to cover a window given in microseconds.
  function automatic int cyc_from_us(input int clk_mhz, input int us);
    return clk_mhz * us;
  endfunction

  // K2 bits [2:0] value that marks line AIS.
  localparam logic [2:0] K2_AIS_CODE = 3'b111;

endpackage

// File: rtl/sts1_rx_sampler.sv
module sts1_rx_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_clk,
  input  logic line_dat,
  output logic clk_edge,
  output logic clk_rise,
  output logic dat_s
);

  localparam int LANES = 2;
  localparam int LANE_CLK = 0;
  localparam int LANE_DAT = 1;

  logic [LANES-1:0] raw;
  logic [STAGES:0]  sh [LANES];

  assign raw[LANE_CLK] = line_clk;
  assign raw[LANE_DAT] = line_dat;

  // One synchroniser chain per lane, plus one extra stage for edge detection.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) sh[g] <= '0;
      else     sh[g] <= {sh[g][STAGES-1:0], raw[g]};
    end
  end

  assign clk_edge = sh[LANE_CLK][STAGES] ^ sh[LANE_CLK][STAGES-1];
  assign clk_rise = sh[LANE_CLK][STAGES-1] & ~sh[LANE_CLK][STAGES];
  assign dat_s    = sh[LANE_DAT][STAGES-1];

endmodule

// File: rtl/sts1_idle_timer.sv
module sts1_idle_timer #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt;

  // Saturating cycle counter, cleared by any qualifying activity.
  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (cnt != LIM_V) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM_V);

  AST_TIMER_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (cnt == LIM_V && !restart) |=> (cnt == LIM_V)); // R2

endmodule

// File: rtl/sts1_persist.sv
module sts1_persist #(
  parameter int SET_N = 5,
  parameter int CLR_N = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cond,
  output logic state
);

  localparam int MAXN = (SET_N > CLR_N) ? SET_N : CLR_N;
  localparam int CW   = $clog2(MAXN + 1);

  logic [CW-1:0] run;
  logic [CW-1:0] goal;

  // Consecutive ticks needed to leave the present state.
  assign goal = state ? CW'(CLR_N) : CW'(SET_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= 1'b0;
      run   <= '0;
    end else if (tick) begin
      if (cond != state) begin
        if ((run + 1'b1) == goal) begin
          state <= ~state;
          run   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end

  AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(state)); // R3, R7

  AST_RUN_BELOW_GOAL: assert property (@(posedge clk) disable iff (rst)
    run < goal); // R4

endmodule

// File: rtl/sts1_oof_tracker.sv
module sts1_oof_tracker #(
  parameter int FRAME_BITS = 6480,
  parameter int BPOS_W     = 16,
  parameter int MISS_N     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick,
  input  logic              fp_found,
  input  logic [BPOS_W-1:0] fp_pos,
  output logic              oof
);

  localparam int MW = $clog2(MISS_N + 1);
  localparam logic [MW-1:0]     MISS_V = MW'(MISS_N);
  localparam logic [BPOS_W-1:0] SPAN_V = BPOS_W'(FRAME_BITS);

  logic [MW-1:0]     miss;
  logic              seen;
  logic [BPOS_W-1:0] last_pos;
  logic              last_vld;
  logic              span_ok;

  assign span_ok = last_vld && ((fp_pos - last_pos) == SPAN_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      oof      <= 1'b0;
      miss     <= '0;
      seen     <= 1'b0;
      last_pos <= '0;
      last_vld <= 1'b0;
    end else begin
      if (fp_found) begin
        last_pos <= fp_pos;
        last_vld <= 1'b1;
      end
      if (oof) begin
        seen <= 1'b0;
        if (fp_found && span_ok) begin
          oof  <= 1'b0;
          miss <= '0;
        end
      end else if (frame_tick) begin
        seen <= 1'b0;
        if (seen || fp_found) begin
          miss <= '0;
        end else if ((miss + 1'b1) == MISS_V) begin
          oof  <= 1'b1;
          miss <= '0;
        end else begin
          miss <= miss + 1'b1;
        end
      end else if (fp_found) begin
        seen <= 1'b1;
      end
    end
  end

  AST_OOF_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(oof) |-> $past(frame_tick)); // R5

  AST_OOF_FALL_ON_PATTERN: assert property (@(posedge clk) disable iff (rst)
    $fell(oof) |-> $past(fp_found)); // R6

  AST_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
    miss < MISS_V); // R5

endmodule

// File: rtl/sts1_line_alarms.sv
module sts1_line_alarms
  import sts1_alarm_pkg::*;
#(
  parameter int SYS_CLK_MHZ = 125,
  parameter int LOC_NS      = 200,
  parameter int LOS_US      = 20,
  parameter int FRAME_BITS  = 6480,
  parameter int BPOS_W      = 16,
  parameter int AIS_SET     = 5,
  parameter int AIS_CLR     = 5,
  parameter int LOF_SET     = 8,
  parameter int LOF_CLR     = 8,
  parameter int OOF_MISS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line_clk,
  input  logic              rx_line_dat,
  input  logic              ext_sig_ok,
  input  logic              fp_found,
  input  logic [BPOS_W-1:0] fp_pos,
  input  logic [7:0]        k2_byte,
  input  logic              k2_stb,
  output logic              alm_loc,
  output logic              alm_ais,
  output logic              alm_lof,
  output logic              alm_oof,
  output logic              alm_los
);

  localparam int LOC_CYC = cyc_from_ns(SYS_CLK_MHZ, LOC_NS);
  localparam int LOS_CYC = cyc_from_us(SYS_CLK_MHZ, LOS_US);
  localparam int FB_W    = $clog2(FRAME_BITS);
  localparam logic [FB_W-1:0] FB_LAST = FB_W'(FRAME_BITS - 1);

  logic rx_edge, rx_rise, rx_dat;
  logic loc_exp, zero_exp;
  logic [FB_W-1:0] bit_cnt;
  logic bit_wrap;
  logic frame_tick;
  logic loc_q, los_q;

  sts1_rx_sampler #(.STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(rst),
    .line_clk(rx_line_clk), .line_dat(rx_line_dat),
    .clk_edge(rx_edge), .clk_rise(rx_rise), .dat_s(rx_dat)
  );

  // Receive clock silence window.
  sts1_idle_timer #(.LIMIT(LOC_CYC)) u_loc_tmr (
    .clk(clk), .rst(rst), .restart(rx_edge), .expired(loc_exp)
  );

  // All-zero data window: any one in the data restarts it.
  sts1_idle_timer #(.LIMIT(LOS_CYC)) u_zero_tmr (
    .clk(clk), .rst(rst), .restart(rx_dat), .expired(zero_exp)
  );

  // Free-running frame-length bit counter on receive clock rising edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
    end else if (rx_rise) begin
      if (bit_cnt == FB_LAST) bit_cnt <= '0;
      else                    bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign bit_wrap   = rx_rise && (bit_cnt == FB_LAST);
  assign frame_tick = alm_lof ? bit_wrap : k2_stb;

  sts1_persist #(.SET_N(AIS_SET), .CLR_N(AIS_CLR)) u_ais (
    .clk(clk), .rst(rst), .tick(k2_stb),
    .cond(k2_byte[2:0] == K2_AIS_CODE), .state(alm_ais)
  );

  sts1_oof_tracker #(
    .FRAME_BITS(FRAME_BITS), .BPOS_W(BPOS_W), .MISS_N(OOF_MISS)
  ) u_oof (
    .clk(clk), .rst(rst), .frame_tick(frame_tick),
    .fp_found(fp_found), .fp_pos(fp_pos), .oof(alm_oof)
  );

  sts1_persist #(.SET_N(LOF_SET), .CLR_N(LOF_CLR)) u_lof (
    .clk(clk), .rst(rst), .tick(frame_tick),
    .cond(alm_oof), .state(alm_lof)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q <= 1'b0;
      los_q <= 1'b0;
    end else begin
      loc_q <= loc_exp;
      if (!ext_sig_ok || zero_exp) los_q <= 1'b1;
      else if (fp_found)           los_q <= 1'b0;
    end
  end

  assign alm_loc = loc_q;
  assign alm_los = los_q;

  AST_LOC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rx_edge |-> ##2 !alm_loc); // R2

  AST_LOS_EXT: assert property (@(posedge clk) disable iff (rst)
    !ext_sig_ok |=> alm_los); // R9

  AST_LOS_CLEAR_QUAL: assert property (@(posedge clk) disable iff (rst)
    $fell(alm_los) |-> $past(fp_found && ext_sig_ok)); // R10

  AST_LOF_INTERNAL_TICK: assert property (@(posedge clk) disable iff (rst)
    (alm_lof && !bit_wrap) |=> $stable(alm_lof)); // R8

endmodule

// File: tb/sim_sts1_line_alarms.sv
module sim_sts1_line_alarms;

  localparam int FB  = 32;
  localparam int BPW = 16;
  localparam int FRAME_CYC = FB * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line_clk = 1'b0;
  logic rx_line_dat = 1'b1;
  logic ext_sig_ok = 1'b1;
  logic fp_found = 1'b0;
  logic [BPW-1:0] fp_pos = '0;
  logic [7:0] k2_byte = '0;
  logic k2_stb = 1'b0;
  logic alm_loc, alm_ais, alm_lof, alm_oof, alm_los;
  logic rx_run = 1'b1;

  int n_chk = 0;
  int n_err = 0;

  sts1_line_alarms #(.FRAME_BITS(FB), .BPOS_W(BPW)) u0 (
    .clk(clk), .rst(rst),
    .rx_line_clk(rx_line_clk), .rx_line_dat(rx_line_dat),
    .ext_sig_ok(ext_sig_ok), .fp_found(fp_found), .fp_pos(fp_pos),
    .k2_byte(k2_byte), .k2_stb(k2_stb),
    .alm_loc(alm_loc), .alm_ais(alm_ais), .alm_lof(alm_lof),
    .alm_oof(alm_oof), .alm_los(alm_los)
  );

  always #4 clk = ~clk;

  // Receive bit clock: one toggle every two system cycles while running.
  initial begin
    forever begin
      @(negedge clk); @(negedge clk);
      if (rx_run) rx_line_clk = ~rx_line_clk;
    end
  end

  // {expected ais after strobe, K2[2:0]}
  localparam logic [3:0] AIS_VEC [19] = '{
    4'b0_111, 4'b0_111, 4'b0_111, 4'b0_101,
    4'b0_111, 4'b0_111, 4'b0_111, 4'b0_111, 4'b1_111,
    4'b1_110, 4'b1_110, 4'b1_110, 4'b1_110, 4'b1_111,
    4'b1_001, 4'b1_001, 4'b1_001, 4'b1_001, 4'b0_001
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic fp_pulse(input int pos);
    fp_pos   = BPW'(pos);
    fp_found = 1'b1;
    tick(1);
    fp_found = 1'b0;
  endtask

  task automatic k2_frame(input logic [2:0] low);
    k2_byte = {5'b10100, low};
    k2_stb  = 1'b1;
    tick(1);
    k2_stb  = 1'b0;
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 loc", alm_loc, 1'b0);
    chk("R1 ais", alm_ais, 1'b0);
    chk("R1 lof", alm_lof, 1'b0);
    chk("R1 oof", alm_oof, 1'b0);
    chk("R1 los", alm_los, 1'b0);

    // R3 / R4 table walk; a pattern pulse in every frame keeps framing
    for (int i = 0; i < 19; i++) begin
      fp_pulse(i * 7);
      k2_frame(AIS_VEC[i][2:0]);
      chk(i < 9 ? "R3 ais set" : "R4 ais clear", alm_ais, AIS_VEC[i][3]);
    end

    // R2 receive clock loss
    rx_run = 1'b0;
    tick(15);
    chk("R2 loc early", alm_loc, 1'b0);
    tick(30);
    chk("R2 loc set", alm_loc, 1'b1);
    rx_run = 1'b1;
    tick(10);
    chk("R2 loc clear", alm_loc, 1'b0);

    // R9 / R10 external input
    ext_sig_ok = 1'b0;
    tick(1);
    chk("R9 los ext", alm_los, 1'b1);
    fp_pulse(500);
    chk("R10 los held ext low", alm_los, 1'b1);
    ext_sig_ok = 1'b1;
    tick(3);
    chk("R10 los held no pattern", alm_los, 1'b1);
    fp_pulse(600);
    chk("R10 los clear", alm_los, 1'b0);

    // R9 / R10 zero data run
    rx_line_dat = 1'b0;
    tick(2400);
    chk("R9 los zero early", alm_los, 1'b0);
    tick(200);
    chk("R9 los zero set", alm_los, 1'b1);
    rx_line_dat = 1'b1;
    tick(10);
    chk("R10 los zero held", alm_los, 1'b1);
    fp_pulse(700);
    chk("R10 los zero clear", alm_los, 1'b0);

    // R5 out of frame: one framed tick, then missing patterns
    k2_frame(3'b000);
    for (int i = 0; i < 3; i++) k2_frame(3'b000);
    chk("R5 oof after three", alm_oof, 1'b0);
    k2_frame(3'b000);
    chk("R5 oof after four", alm_oof, 1'b1);

    // R6 spacing rule
    fp_pulse(100);
    chk("R6 first pattern", alm_oof, 1'b1);
    fp_pulse(100 + FB - 1);
    chk("R6 wrong spacing", alm_oof, 1'b1);
    fp_pulse(100 + FB - 1 + FB);
    chk("R6 exact spacing", alm_oof, 1'b0);

    // R7 loss of frame
    for (int i = 0; i < 4; i++) k2_frame(3'b000);
    for (int i = 0; i < 7; i++) k2_frame(3'b000);
    chk("R7 lof after seven", alm_lof, 1'b0);
    k2_frame(3'b000);
    chk("R7 lof after eight", alm_lof, 1'b1);

    // R8 internal ticks clear loss of frame without K2 strobes
    fp_pulse(1000);
    fp_pulse(1000 + FB);
    chk("R8 reframed", alm_oof, 1'b0);
    for (int i = 0; i < (6 * FRAME_CYC) / 64; i++) begin
      tick(63);
      fp_pulse(2000 + i);
    end
    chk("R8 lof held", alm_lof, 1'b1);
    for (int i = 0; i < (3 * FRAME_CYC) / 64; i++) begin
      tick(63);
      fp_pulse(3000 + i);
    end
    chk("R7 R8 lof clear", alm_lof, 1'b0);
    chk("R8 oof stays clear", alm_oof, 1'b0);

    summary();
    $finish;
  end

endmodule